// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block turns a fast serial system clock into the two timing signals that a serial audio port needs: a bit clock with a 50% duty cycle, and a frame sync that marks the first bit of every frame. The bit clock period is set by a chain of dividers. An optional halving stage, an optional divide-by-eight prescaler and a modulus divider are multiplied together, and a final toggle stage follows them. A frame counter then counts bit clock rising edges over a programmable number of words, each of a programmable number of bits.

The frame sync can come from the internal generator or from an external pin. Settings are sampled while the block is idle and again at each frame boundary, so a frame never mixes two configurations partway through a bit. A divider setting in which every stage divides by one is illegal. It raises an error flag and keeps the outputs quiet.

Top module: `audclk_gen`

## Requirements
- R1: The bit clock period is 2·H system clock cycles, where H = (half_en_i+1)·(oct_en_i ? 8 : 1)·(mod_i+1). The clock is high for exactly H of those cycles.
- R2: In internal mode the frame sync rises on the same clock edge as a bit clock rising edge. It rises again every L = (wlen_m1_i+1)·(words_m1_i+1) bit clock rising edges, where wlen_m1_i+1 is the bits per word and words_m1_i+1 is the words per frame.
- R3: The internal frame sync stays high for exactly one bit clock period, from the rise of the first bit of a frame to the rise of the second bit (it stays high continuously when L = 1).
- R4: When the latched frame-sync source is 1, fs_o comes from the internal generator. When it is 0, fs_o follows fs_ext_i combinationally while the block runs.
- R5: When half_en_i, oct_en_i and mod_i are all zero in the latched setting, cfg_err_o is 1 and bclk_o and fs_o stay 0, whatever fs_ext_i does.
- R6: A change of the divider or frame inputs made during a frame takes effect at the end of that frame. The high phase of the last bit uses the old half period H, and the low phase that follows uses the new one.
- R7: Whenever en_i is 0, fs_o is 0 and bclk_o is 0 from the next clock edge onward. After enable, the first bit clock rising edge starts a new frame with the frame sync high.
- R8: After reset, bclk_o and fs_o are 0 and cfg_err_o is 0. Settings are reloaded every cycle while the block is disabled or in error, so a corrected setting clears cfg_err_o one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears all counters |
| half_en_i | input | 1 | Adds a divide-by-2 stage |
| oct_en_i | input | 1 | Adds a divide-by-8 stage |
| mod_i | input | PM_W | Modulus stage divides by mod_i+1 |
| words_m1_i | input | DC_W | Words per frame minus one |
| wlen_m1_i | input | WL_W | Bits per word minus one |
| fs_gen_i | input | 1 | 1 selects the internal frame sync, 0 the external one |
| fs_ext_i | input | 1 | External frame sync |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| cfg_err_o | output | 1 | Illegal divider setting |

## Verification
The assertions assume that the divider and frame inputs only matter once they are latched. They also assume that the modulus and frame counters never start a frame with a count above the latched limit, which holds because settings are taken only when the counters are at zero. The stimulus changes settings only while the block is disabled, except in the directed frame-boundary case and the error-recovery case. It keeps random half periods and frame lengths small enough that a frame and a half fit in the run. The external-sync case toggles fs_ext_i only between clock edges, so the combinational path is checked apart from any register.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

   typedef enum logic {
      FS_EXTERNAL = 1'b0,
      FS_INTERNAL = 1'b1
   } fs_src_e;

   localparam int PRE_W = 5;

   // Product of the optional halving and octave prescale stages: 1, 2, 8 or 16.
   function automatic logic [PRE_W-1:0] pre_factor(input logic half_en, input logic oct_en);
      logic [PRE_W-1:0] f;
      f = oct_en ? PRE_W'(8) : PRE_W'(1);
      return half_en ? (f << 1) : f;
   endfunction

endpackage

// File: rtl/audclk_divchain.sv
module audclk_divchain #(
   parameter int PM_W    = 8,
   parameter bit CASCADE = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            run_i,
   input  logic            half_en_i,
   input  logic            oct_en_i,
   input  logic [PM_W-1:0] mod_i,
   output logic            tick_o
);
   import audclk_pkg::*;

   localparam int CNT_W = PRE_W + PM_W;

   generate
      if (CASCADE) begin : g_cascade
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] pre_last;
         logic [PM_W-1:0]  mod_q;
         logic             pre_wrap;

         assign pre_last = pre_factor(half_en_i, oct_en_i) - PRE_W'(1);
         assign pre_wrap = (pre_q == pre_last);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pre_q <= '0;
               mod_q <= '0;
            end else if (!run_i) begin
               pre_q <= '0;
               mod_q <= '0;
            end else if (pre_wrap) begin
               pre_q <= '0;
               mod_q <= (mod_q == mod_i) ? '0 : mod_q + PM_W'(1);
            end else begin
               pre_q <= pre_q + PRE_W'(1);
            end
         end

         assign tick_o = run_i && pre_wrap && (mod_q == mod_i);
      end else begin : g_flat
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] span;
         logic [CNT_W-1:0] last;

         assign span = CNT_W'(pre_factor(half_en_i, oct_en_i)) * (CNT_W'(mod_i) + CNT_W'(1));
         assign last = span - CNT_W'(1);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                     cnt_q <= '0;
            else if (!run_i || cnt_q == last) cnt_q <= '0;
            else                              cnt_q <= cnt_q + CNT_W'(1);
         end

         assign tick_o = run_i && (cnt_q == last);
      end
   endgenerate

endmodule

// File: rtl/audclk_framer.sv
module audclk_framer #(
   parameter int WL_W = 5,
   parameter int DC_W = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            run_i,
   input  logic            tick_i,
   input  logic [WL_W-1:0] wlen_m1_i,
   input  logic [DC_W-1:0] words_m1_i,
   output logic            bclk_o,
   output logic            fs_o,
   output logic            frame_end_o
);
   logic            bclk_q;
   logic            fs_q;
   logic [WL_W-1:0] bit_q;
   logic [DC_W-1:0] word_q;
   logic            at_start;
   logic            rise;

   // bit_q/word_q name the bit that the next rising edge will start.
   assign at_start = (bit_q == '0) && (word_q == '0);
   assign rise     = tick_i && !bclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_q <= 1'b0;
         fs_q   <= 1'b0;
         bit_q  <= '0;
         word_q <= '0;
      end else if (!run_i) begin
         bclk_q <= 1'b0;
         fs_q   <= 1'b0;
         bit_q  <= '0;
         word_q <= '0;
      end else begin
         if (tick_i) bclk_q <= ~bclk_q;
         if (rise) begin
            fs_q <= at_start;
            if (bit_q == wlen_m1_i) begin
               bit_q  <= '0;
               word_q <= (word_q == words_m1_i) ? '0 : word_q + DC_W'(1);
            end else begin
               bit_q <= bit_q + WL_W'(1);
            end
         end
      end
   end

   assign bclk_o      = bclk_q;
   assign fs_o        = fs_q;
   assign frame_end_o = tick_i && bclk_q && at_start;

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
   parameter int PM_W    = 8,
   parameter int DC_W    = 5,
   parameter int WL_W    = 5,
   parameter bit CASCADE = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            half_en_i,
   input  logic            oct_en_i,
   input  logic [PM_W-1:0] mod_i,
   input  logic [DC_W-1:0] words_m1_i,
   input  logic [WL_W-1:0] wlen_m1_i,
   input  logic            fs_gen_i,
   input  logic            fs_ext_i,
   output logic            bclk_o,
   output logic            fs_o,
   output logic            cfg_err_o
);
   import audclk_pkg::*;

   generate
      if (PM_W < 1 || PM_W > 12) begin : g_bad_pm
         $error("audclk_gen: PM_W must be 1..12");
      end
      if (DC_W < 1 || DC_W > 8) begin : g_bad_dc
         $error("audclk_gen: DC_W must be 1..8");
      end
      if (WL_W < 1 || WL_W > 8) begin : g_bad_wl
         $error("audclk_gen: WL_W must be 1..8");
      end
   endgenerate

   typedef struct packed {
      logic            half;
      logic            oct;
      logic [PM_W-1:0] modv;
      logic [DC_W-1:0] words;
      logic [WL_W-1:0] wlen;
      fs_src_e         src;
   } cfg_t;

   cfg_t live;
   cfg_t act_q;
   logic err;
   logic run;
   logic reload;
   logic tick;
   logic frame_end;
   logic fs_int;

   assign live = '{half: half_en_i, oct: oct_en_i, modv: mod_i, words: words_m1_i,
                   wlen: wlen_m1_i, src: fs_src_e'(fs_gen_i)};

   assign err    = !act_q.half && !act_q.oct && (act_q.modv == '0);
   assign run    = en_i && !err;
   assign reload = !en_i || err || frame_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q <= '{half: 1'b1, oct: 1'b0, modv: '0, words: '0, wlen: '0, src: FS_EXTERNAL};
      else if (reload) act_q <= live;
   end

   audclk_divchain #(.PM_W(PM_W), .CASCADE(CASCADE)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .half_en_i (act_q.half),
      .oct_en_i  (act_q.oct),
      .mod_i     (act_q.modv),
      .tick_o    (tick)
   );

   audclk_framer #(.WL_W(WL_W), .DC_W(DC_W)) u_frm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .tick_i      (tick),
      .wlen_m1_i   (act_q.wlen),
      .words_m1_i  (act_q.words),
      .bclk_o      (bclk_o),
      .fs_o        (fs_int),
      .frame_end_o (frame_end)
   );

   assign fs_o      = run && ((act_q.src == FS_INTERNAL) ? fs_int : fs_ext_i);
   assign cfg_err_o = err;

endmodule

// File: rtl/audclk_chk.sv
module audclk_chk #(
   parameter int CFG_W = 21
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic             bclk_o,
   input logic             fs_o,
   input logic             cfg_err_o,
   input logic             run,
   input logic             tick,
   input logic             frame_end,
   input logic             fs_int,
   input logic [CFG_W-1:0] act_cfg
);
   // R5: an illegal divider keeps both outputs quiet
   a_r5_idle_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |-> (!bclk_o && !fs_o));

   // R7: disable silences the frame sync now and the bit clock after one edge
   a_r7_fs_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> !fs_o);
   a_r7_bclk_off_after_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !bclk_o);

   // R1: the bit clock moves only on a divider terminal count while running
   a_r1_bclk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(bclk_o) |-> ($past(tick) || !$past(run)));

   // R2: the internal frame sync rises together with the bit clock
   a_r2_fs_with_bclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fs_int) |-> $rose(bclk_o));

   // R6: latched settings change only at a frame end, while idle, or in error
   a_r6_cfg_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_cfg) |-> ($past(frame_end) || !$past(en_i) || $past(cfg_err_o)));

endmodule

bind audclk_gen audclk_chk #(.CFG_W(3 + PM_W + DC_W + WL_W)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .en_i      (en_i),
   .bclk_o    (bclk_o),
   .fs_o      (fs_o),
   .cfg_err_o (cfg_err_o),
   .run       (run),
   .tick      (tick),
   .frame_end (frame_end),
   .fs_int    (fs_int),
   .act_cfg   (act_q)
);

// File: tb/audclk_gen_tb_top.sv
module audclk_gen_tb_top;
   localparam int PM_W = 8;
   localparam int DC_W = 5;
   localparam int WL_W = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            en = 1'b0;
   logic            half_en = 1'b1;
   logic            oct_en = 1'b0;
   logic [PM_W-1:0] modv = '0;
   logic [DC_W-1:0] words = '0;
   logic [WL_W-1:0] wlen = '0;
   logic            fs_gen = 1'b1;
   logic            fs_ext = 1'b0;
   logic            bclk, fs, cerr;

   int n_chk = 0;
   int n_err = 0;
   logic last_b = 1'b0;

   always #5 clk = ~clk;

   audclk_gen #(.PM_W(PM_W), .DC_W(DC_W), .WL_W(WL_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .half_en_i(half_en), .oct_en_i(oct_en),
      .mod_i(modv), .words_m1_i(words), .wlen_m1_i(wlen), .fs_gen_i(fs_gen),
      .fs_ext_i(fs_ext), .bclk_o(bclk), .fs_o(fs), .cfg_err_o(cerr)
   );

   function automatic int half_period(input bit h, input bit o, input int m);
      return (h ? 2 : 1) * (o ? 8 : 1) * (m + 1);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Waits for the next bit clock rising edge, sampling at falling clock edges.
   task automatic next_rise(output int dt, output int hi, output bit fs_at, output bit fs_before);
      dt = 0; hi = 0; fs_at = 1'b0; fs_before = 1'b0;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         dt++;
         if (bclk) hi++;
         if (bclk && !last_b) begin
            fs_at = fs;
            last_b = bclk;
            break;
         end
         fs_before = fs;
         last_b = bclk;
      end
   endtask

   task automatic start(input bit h, input bit o, input int m, input int dc, input int wl, input bit gen);
      en = 1'b0;
      @(negedge clk);
      half_en = h; oct_en = o; modv = PM_W'(m); words = DC_W'(dc); wlen = WL_W'(wl); fs_gen = gen;
      repeat (2) @(negedge clk);
      last_b = bclk;
      en = 1'b1;
   endtask

   task automatic stop_and_check();
      en = 1'b0;
      #1 chk(fs == 1'b0, "R7 fs low on disable", fs, 0);
      @(negedge clk);
      chk(bclk == 1'b0, "R7 bclk low after disable", bclk, 0);
      last_b = 1'b0;
   endtask

   task automatic run_case(input bit h, input bit o, input int m, input int dc, input int wl);
      int n, fl, dt, hi;
      bit fa, fb;
      n  = half_period(h, o, m);
      fl = (wl + 1) * (dc + 1);
      start(h, o, m, dc, wl, 1'b1);
      next_rise(dt, hi, fa, fb);
      chk(fa == 1'b1, "R7 first bit starts frame", fa, 1);
      for (int i = 1; i <= fl + 1; i++) begin
         next_rise(dt, hi, fa, fb);
         chk(dt == 2 * n, "R1 bclk period", dt, 2 * n);
         chk(hi == n, "R1 bclk high time", hi, n);
         chk(fa == ((i % fl) == 0), "R2 fs at bit rise", fa, int'((i % fl) == 0));
         chk(fb == (((i - 1) % fl) == 0), "R3 fs held over bit", fb, int'(((i - 1) % fl) == 0));
      end
      stop_and_check();
   endtask

   initial begin
      int dt, hi, n_old, n_new;
      bit fa, fb;
      bit ok;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      chk(bclk == 1'b0, "R8 bclk in reset", bclk, 0);
      chk(fs == 1'b0, "R8 fs in reset", fs, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cerr == 1'b0, "R8 no error after reset", cerr, 0);

      // Directed: 12 MHz example ratio (H=4, 16-bit words, 2 words)
      run_case(1'b1, 1'b0, 1, 1, 15);
      // Directed: 19.2 MHz example ratio (H=150, 8-bit words, 2 words)
      run_case(1'b1, 1'b0, 74, 1, 7);
      // Directed: longest divider, one-bit frame
      run_case(1'b1, 1'b1, 255, 0, 0);
      // Directed: smallest legal divider
      run_case(1'b0, 1'b0, 1, 2, 1);
      // Directed: prescaler alone
      run_case(1'b0, 1'b1, 0, 0, 2);

      // Constrained random
      for (int c = 0; c < 5; c++) begin
         bit h, o;
         int m;
         h = 1'($urandom % 2);
         o = 1'($urandom % 2);
         m = int'($urandom % 8);
         if (!h && !o && m == 0) m = 1;
         run_case(h, o, m, int'($urandom % 4), int'($urandom % 8));
      end

      // R6: setting change during a frame applies at its end
      n_old = half_period(1'b1, 1'b0, 2);
      n_new = half_period(1'b1, 1'b0, 4);
      start(1'b1, 1'b0, 2, 0, 3, 1'b1);
      next_rise(dt, hi, fa, fb);
      modv = PM_W'(4);
      for (int i = 1; i <= 4; i++) begin
         next_rise(dt, hi, fa, fb);
         if (i < 4) chk(dt == 2 * n_old, "R6 old period within frame", dt, 2 * n_old);
         else       chk(dt == n_old + n_new, "R6 boundary period", dt, n_old + n_new);
      end
      chk(fa == 1'b1, "R6 new frame starts", fa, 1);
      next_rise(dt, hi, fa, fb);
      chk(dt == 2 * n_new, "R6 new period", dt, 2 * n_new);
      stop_and_check();

      // R5: illegal divider, external source selected
      fs_ext = 1'b1;
      start(1'b0, 1'b0, 0, 0, 3, 1'b0);
      @(negedge clk);
      chk(cerr == 1'b1, "R5 error flag", cerr, 1);
      ok = 1'b1;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (bclk || fs) ok = 1'b0;
      end
      chk(ok, "R5 outputs idle in error", ok, 1);
      // R8: correcting the setting clears the flag one clock later
      modv = PM_W'(3);
      @(negedge clk);
      chk(cerr == 1'b0, "R8 error cleared", cerr, 0);
      last_b = bclk;
      next_rise(dt, hi, fa, fb);
      chk(fa == 1'b1, "R4 external sync passes high", fa, 1);
      @(negedge clk);
      fs_ext = 1'b0;
      #1 chk(fs == 1'b0, "R4 external sync passes low", fs, 0);
      fs_ext = 1'b1;
      #1 chk(fs == 1'b1, "R4 external sync passes high again", fs, 1);
      stop_and_check();
      fs_ext = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule